// File: doc/BRIEF.md
# Page Write Load Controller

This block handles the write side of a byte-wide nonvolatile memory organised as 8K x 8. A host drives three active-low strobes (select, write, output enable), a 13-bit address and an 8-bit data byte. Each accepted write strobe loads one byte into a 32-byte page buffer. The low five address bits pick the slot within the page, so bytes may arrive in any order. The upper eight bits pick the page. A per-slot valid bit records which slots hold new data.

Committing the page is triggered by inactivity. A window counter restarts each time the write strobe goes inactive and is cleared again when a new strobe begins. When the host stays quiet for the whole window, the block raises a busy flag for a fixed program time. At the end of that time it writes only the loaded slots into the cell array, which is modelled as rows of registers, and clears the valid bits.

All times are counted in clock cycles. The strobes are sampled synchronously through one register stage. The host side is a plain strobe interface with no back-pressure. While busy is high, any write the host attempts is dropped without effect, and the host is expected to poll busy. A separate combinational read port shows the committed array contents.

Top module: `pgw_ctrl`

## Requirements
- R1: A write is active only while select is low, write is low and output enable is high. Output enable low, or select high, keeps the array, the page buffer and busy unchanged.
- R2: A write that stays active for fewer than FILT_CYC sampled cycles is discarded. A write active for FILT_CYC cycles or more loads one byte.
- R3: The address is taken in the first cycle that the write is active (the later of the two falling strobes). The data is taken in the last active cycle (the earlier of the two rising strobes).
- R4: Address bits 4..0 select one of 32 page slots. Slots may be loaded in any order. Loading the same slot again keeps the newest byte.
- R5: The page written is given by address bits 12..5 of the last accepted load.
- R6: Busy rises WIN_CYC+1 to WIN_CYC+3 cycles after the last write ends, provided no write becomes active in between and at least one slot is loaded. Gaps shorter than WIN_CYC between writes never raise busy.
- R7: Busy stays high for exactly PROG_CYC cycles. The array row is updated and all valid bits are cleared as busy falls, so reads during busy return the old contents.
- R8: Slots of the page that were not loaded keep their previous array contents.
- R9: Writes that complete while busy is high are ignored: no byte is loaded and no further program cycle follows.
- R10: After reset, busy is low, no slot is pending, and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel_n | input | 1 | Active-low device select |
| wr_strobe_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable; low blocks writes |
| wr_addr | input | 13 | Write address: bits 12..5 page, bits 4..0 slot |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 13 | Read address into the array |
| rd_data | output | 8 | Array byte at rd_addr, combinational |
| prog_busy | output | 1 | High while a program cycle runs |

## Verification
The bench builds the block with FILT_CYC = 2, WIN_CYC = 40 and PROG_CYC = 100. A filter of two cycles lets a one-cycle strobe serve as the too-short case while a two-cycle strobe is the shortest accepted case. A 40-cycle window lets the bench keep gaps of 35 cycles that must not commit, and still measure the exact cycle at which busy rises. A 100-cycle program time makes room to read old contents and to attempt a dropped write while busy is high, and each full commit stays around 150 cycles.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ADDR_W     = 13;
  localparam int DATA_W     = 8;
  localparam int OFS_W      = 5;
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int PAGE_W     = ADDR_W - OFS_W;
  localparam int NUM_PAGES  = 1 << PAGE_W;
  localparam int ROW_W      = PAGE_BYTES * DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } byte_load_t;
endpackage

// File: rtl/pgw_strobe_filt.sv
// Samples host strobes, rejects short pulses, captures address and data.
module pgw_strobe_filt
  import pgw_pkg::*;
#(
  parameter int FILT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              wr_strobe_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              act_o,
  output logic              load_vld_o,
  output byte_load_t        load_o
);
  localparam int CW = $clog2(FILT_CYC + 1) + 1;

  logic              sel_q, wr_q, oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              act, act_prev;
  logic [CW-1:0]     run_cnt;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      wr_q   <= 1'b1;
      oe_q   <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      sel_q  <= chip_sel_n;
      wr_q   <= wr_strobe_n;
      oe_q   <= out_en_n;
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  assign act = ~sel_q & ~wr_q & oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev <= 1'b0;
      run_cnt  <= '0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      act_prev <= act;
      if (act) begin
        cap_data <= data_q;
        if (!act_prev) begin
          cap_addr <= addr_q;
          run_cnt  <= CW'(1);
        end else if (run_cnt != CW'(FILT_CYC)) begin
          run_cnt <= run_cnt + CW'(1);
        end
      end
    end
  end

  assign act_o       = act;
  assign load_vld_o  = act_prev & ~act & (run_cnt >= CW'(FILT_CYC));
  assign load_o.addr = cap_addr;
  assign load_o.data = cap_data;
endmodule

// File: rtl/pgw_page_buf.sv
// 32-slot page buffer with per-slot valid bits.
module pgw_page_buf
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  byte_load_t        load,
  input  logic              clr,
  output logic [PAGE_W-1:0] page_o,
  output logic [PAGE_BYTES-1:0] vld_o,
  output logic [ROW_W-1:0]  row_o
);
  logic [DATA_W-1:0] slot [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_o <= '0;
    else if (wr_en) page_o <= load.addr[ADDR_W-1:OFS_W];
  end

  genvar g;
  for (g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (load.addr[OFS_W-1:0] == OFS_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_o[g] <= 1'b0;
        slot[g]  <= '0;
      end else if (clr) begin
        vld_o[g] <= 1'b0;
      end else if (hit) begin
        vld_o[g] <= 1'b1;
        slot[g]  <= load.data;
      end
    end

    assign row_o[g*DATA_W +: DATA_W] = slot[g];
  end
endmodule

// File: rtl/pgw_seq.sv
// Byte-load window timer and self-timed program sequencer.
module pgw_seq #(
  parameter int WIN_CYC  = 10000,
  parameter int PROG_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_act,
  input  logic pending,
  output logic busy_o,
  output logic commit_o
);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1);

  logic [WW-1:0] win_cnt;
  logic [PW-1:0] prog_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      win_cnt  <= '0;
      prog_cnt <= '0;
    end else if (busy_o) begin
      win_cnt <= '0;
      if (prog_cnt == PW'(PROG_CYC - 1)) begin
        busy_o   <= 1'b0;
        prog_cnt <= '0;
      end else begin
        prog_cnt <= prog_cnt + PW'(1);
      end
    end else if (host_act || !pending) begin
      win_cnt <= '0;
    end else if (win_cnt == WW'(WIN_CYC - 1)) begin
      busy_o   <= 1'b1;
      win_cnt  <= '0;
      prog_cnt <= '0;
    end else begin
      win_cnt <= win_cnt + WW'(1);
    end
  end

  assign commit_o = busy_o && (prog_cnt == PW'(PROG_CYC - 1));
endmodule

// File: rtl/pgw_array.sv
// Cell array model: one register row per page, merged write of loaded slots.
module pgw_array
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_BYTES-1:0] vld,
  input  logic [ROW_W-1:0]  new_row,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [ROW_W-1:0]  mem [NUM_PAGES];
  logic [ROW_W-1:0]  cur_row, merged, rd_row;
  logic [DATA_W-1:0] rd_bytes [PAGE_BYTES];

  assign cur_row = mem[page];
  assign rd_row  = mem[rd_addr[ADDR_W-1:OFS_W]];

  genvar g;
  for (g = 0; g < PAGE_BYTES; g++) begin : g_merge
    assign merged[g*DATA_W +: DATA_W] = vld[g] ? new_row[g*DATA_W +: DATA_W]
                                               : cur_row[g*DATA_W +: DATA_W];
    assign rd_bytes[g] = rd_row[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PAGES; i++) mem[i] <= '1;
    end else if (commit) begin
      mem[page] <= merged;
    end
  end

  assign rd_data = rd_bytes[rd_addr[OFS_W-1:0]];
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int FILT_CYC = 2,
  parameter int WIN_CYC  = 10000,
  parameter int PROG_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              wr_strobe_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              prog_busy
);
  logic                  host_act;
  logic                  load_vld;
  byte_load_t            load;
  logic                  load_ok;
  logic                  commit;
  logic [PAGE_W-1:0]     pend_page;
  logic [PAGE_BYTES-1:0] pend_vld;
  logic [ROW_W-1:0]      pend_row;

  pgw_strobe_filt #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel_n (chip_sel_n),
    .wr_strobe_n(wr_strobe_n),
    .out_en_n   (out_en_n),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .act_o      (host_act),
    .load_vld_o (load_vld),
    .load_o     (load)
  );

  assign load_ok = load_vld & ~prog_busy;

  pgw_page_buf u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (load_ok),
    .load  (load),
    .clr   (commit),
    .page_o(pend_page),
    .vld_o (pend_vld),
    .row_o (pend_row)
  );

  pgw_seq #(.WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_act(host_act),
    .pending (|pend_vld),
    .busy_o  (prog_busy),
    .commit_o(commit)
  );

  pgw_array u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .page   (pend_page),
    .vld    (pend_vld),
    .new_row(pend_row),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk
  import pgw_pkg::*;
#(
  parameter int PROG_CYC = 500000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  act,
  input logic [PAGE_BYTES-1:0] vld
);
  localparam int RW = $clog2(PROG_CYC + 2) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + RW'(1);
    else           run_len <= '0;
  end

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == RW'(PROG_CYC)));

  assert_vld_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (vld == '0));

  assert_busy_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (vld != '0));

  assert_rise_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(act));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vld));
endmodule

bind pgw_ctrl pgw_ctrl_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .busy (prog_busy),
  .act  (host_act),
  .vld  (pend_vld)
);

// File: tb/pgw_ctrl_tb.sv
module pgw_ctrl_tb;
  localparam int FILT = 2;
  localparam int WIN  = 40;
  localparam int PROG = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_sel_n = 1'b1;
  logic        wr_strobe_n = 1'b1;
  logic        out_en_n = 1'b1;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [12:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        prog_busy;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pgw_ctrl #(.FILT_CYC(FILT), .WIN_CYC(WIN), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_strobe_n(wr_strobe_n),
    .out_en_n(out_en_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .prog_busy(prog_busy)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [12:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(req, rd_data == exp, rd_data, exp);
  endtask

  task automatic host_write(input logic [12:0] a, input logic [7:0] d, input int n_low);
    @(negedge clk);
    wr_addr = a; wr_data = d;
    chip_sel_n = 1'b0; wr_strobe_n = 1'b0;
    repeat (n_low) @(negedge clk);
    chip_sel_n = 1'b1; wr_strobe_n = 1'b1;
  endtask

  task automatic expect_commit(input string req);
    int rise_k = 0;
    int len = 0;
    for (int k = 1; k <= WIN + 3 && rise_k == 0; k++) begin
      @(negedge clk);
      if (prog_busy) rise_k = k;
    end
    chk({req, " R6 busy rise"}, rise_k >= WIN + 1 && rise_k <= WIN + 3, rise_k, WIN + 2);
    while (prog_busy) begin
      len++;
      @(negedge clk);
    end
    chk({req, " R7 busy length"}, len == PROG, len, PROG);
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    bit seen = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (prog_busy) seen = 1;
    end
    chk(req, !seen, seen, 0);
  endtask

  task automatic t_reset;
    chk("R10 busy after reset", prog_busy == 1'b0, prog_busy, 0);
    rd_chk("R10 erased low", 13'h0000, 8'hFF);
    rd_chk("R10 erased high", 13'h1FFF, 8'hFF);
    expect_quiet("R10 no pending program", WIN + 10);
  endtask

  task automatic t_single;
    host_write(13'h0123, 8'h5A, 3);
    expect_commit("single");
    rd_chk("R7 single byte written", 13'h0123, 8'h5A);
    rd_chk("R8 neighbour untouched", 13'h0120, 8'hFF);
  endtask

  task automatic t_page;
    host_write({8'h10, 5'd3}, 8'h33, 2);
    expect_commit("page prep");
    host_write({8'h11, 5'd7}, 8'h77, 2); repeat (5) @(negedge clk);
    host_write({8'h10, 5'd2}, 8'h22, 2); repeat (5) @(negedge clk);
    host_write({8'h10, 5'd31}, 8'h3F, 3); repeat (5) @(negedge clk);
    host_write({8'h10, 5'd2}, 8'h2A, 2); repeat (5) @(negedge clk);
    host_write({8'h10, 5'd0}, 8'h01, 2);
    expect_commit("page");
    rd_chk("R5 early slot lands in last page", {8'h10, 5'd7}, 8'h77);
    rd_chk("R5 earlier page not written", {8'h11, 5'd7}, 8'hFF);
    rd_chk("R4 reloaded slot keeps newest", {8'h10, 5'd2}, 8'h2A);
    rd_chk("R4 slot 31", {8'h10, 5'd31}, 8'h3F);
    rd_chk("R4 slot 0", {8'h10, 5'd0}, 8'h01);
    rd_chk("R8 unloaded slot keeps old data", {8'h10, 5'd3}, 8'h33);
  endtask

  task automatic t_glitch;
    host_write(13'h0400, 8'h99, 1);
    expect_quiet("R2 short strobe no program", WIN + 10);
    rd_chk("R2 short strobe no write", 13'h0400, 8'hFF);
    host_write(13'h0400, 8'h98, FILT);
    expect_commit("R2 minimum strobe");
    rd_chk("R2 minimum strobe written", 13'h0400, 8'h98);
  endtask

  task automatic t_inhibit;
    @(negedge clk);
    wr_addr = 13'h0500; wr_data = 8'h44;
    out_en_n = 1'b0; chip_sel_n = 1'b0; wr_strobe_n = 1'b0;
    repeat (4) @(negedge clk);
    chip_sel_n = 1'b1; wr_strobe_n = 1'b1; out_en_n = 1'b1;
    expect_quiet("R1 output enable blocks", WIN + 10);
    rd_chk("R1 output enable blocks data", 13'h0500, 8'hFF);
    @(negedge clk);
    wr_strobe_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_strobe_n = 1'b1;
    expect_quiet("R1 deselected blocks", WIN + 10);
    rd_chk("R1 deselected blocks data", 13'h0500, 8'hFF);
  endtask

  task automatic t_capture;
    @(negedge clk);
    wr_addr = 13'h0600; wr_data = 8'h10;
    chip_sel_n = 1'b0; wr_strobe_n = 1'b0;
    @(negedge clk);
    wr_addr = 13'h0601; wr_data = 8'h20;
    repeat (2) @(negedge clk);
    wr_data = 8'h30;
    @(negedge clk);
    chip_sel_n = 1'b1; wr_strobe_n = 1'b1;
    wr_data = 8'h40;
    expect_commit("capture");
    rd_chk("R3 address from strobe start", 13'h0600, 8'h30);
    rd_chk("R3 later address not used", 13'h0601, 8'hFF);
  endtask

  task automatic t_window;
    bit seen = 0;
    for (int i = 0; i < 4; i++) begin
      host_write(13'h0700 + 13'(i), 8'hC0 + 8'(i), 2);
      for (int k = 0; k < WIN - 5; k++) begin
        @(negedge clk);
        if (prog_busy) seen = 1;
      end
    end
    chk("R6 short gaps never commit", !seen, seen, 0);
    rd_chk("R6 not yet written", 13'h0701, 8'hFF);
    host_write(13'h0704, 8'hC4, 2);
    expect_commit("window");
    rd_chk("R6 first of burst", 13'h0700, 8'hC0);
    rd_chk("R6 last of burst", 13'h0704, 8'hC4);
  endtask

  task automatic t_busy_ignore;
    int guard = 0;
    host_write(13'h0800, 8'h11, 2);
    while (!prog_busy && guard < WIN + 10) begin
      @(negedge clk);
      guard++;
    end
    chk("R7 busy reached", prog_busy == 1'b1, prog_busy, 1);
    rd_chk("R7 old contents while busy", 13'h0800, 8'hFF);
    host_write(13'h0801, 8'h22, 3);
    while (prog_busy) @(negedge clk);
    rd_chk("R7 committed after busy", 13'h0800, 8'h11);
    expect_quiet("R9 no second program", WIN + 10);
    rd_chk("R9 write during busy dropped", 13'h0801, 8'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_page();
    t_glitch();
    t_inhibit();
    t_capture();
    t_window();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule